// File: doc/BRIEF.md
# LED matrix scan driver

This block lights a small LED matrix one line at a time. A single scan position advances on every clock. Its low bits set how long each line stays lit, and its high bits choose which stored row pattern goes to the data bus. A one-hot line-enable strobe moves along with the select field, so the physical line being enabled always matches the pattern on the bus. Whatever holds the frame image (game logic, a register file) drives the row inputs, and the driver reads them live.

Every period in the scan is a power of two, so no divider or modulo logic is needed. The dwell per line is 2^DWELL_BITS clocks, there are 2^SEL_BITS select slots, and a full frame takes the product of the two. When there are fewer stored rows than slots, the spare slots put an all-zero pattern on the bus. Their strobe bit still lights, but that line shows nothing.

Top module: `led_scan_driver`

## Requirements
- R1: While `rst` is high at a rising edge, the scan returns to slot 0. After that edge `strobe_o` is 1 (bit 0 only) and `data_o` shows row 0.
- R2: Each slot stays on the outputs for exactly 2^DWELL_BITS clocks (8 by default) before it advances.
- R3: For a slot code k below NUM_ROWS, `data_o` equals `rows_i[k*ROW_W +: ROW_W]`. With the defaults, codes 0 to 6 give the seven rows in ascending order.
- R4: For any slot code of NUM_ROWS or above (code 7 by default), `data_o` is all zeros, whatever the row inputs hold.
- R5: In every cycle out of reset, exactly one bit of `strobe_o` is high.
- R6: The lit strobe bit index equals the slot code. The strobe rotates up by one position in the same clock in which the slot code increments.
- R7: After the last slot, the scan wraps to slot 0 (strobe bit 0). A full frame lasts 2^(SEL_BITS+DWELL_BITS) clocks (64 by default).
- R8: `data_o` follows the row inputs with no clock of delay. Changing the row of the current slot changes `data_o` at once. Changing any other row leaves `data_o` unchanged.
- R9: A reset asserted in the middle of a frame restarts the scan at slot 0 with a full-length dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rows_i | input | NUM_ROWS*ROW_W | Frame image; row k occupies bits [k*ROW_W +: ROW_W] |
| data_o | output | ROW_W | Pattern of the currently selected row (zero in spare slots) |
| strobe_o | output | 2^SEL_BITS | One-hot line enable; bit k lit during slot k |

## Verification
The checker checks on every cycle that the strobe is one-hot and that each change is a single-step rotation. It also checks that the bus carries the row (or blank) matching the lit strobe bit, and that each dwell after the first full one lasts 2^DWELL_BITS clocks. Only the bench scenarios can show certain other behaviour: where the scan sits relative to reset release, the 64-clock frame wrap, the immediate bus response to edits of selected and unselected rows, and the restart after a reset in mid-frame. They run against a bench counter model, with random frame images and random reset pulses.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    // Default geometry of the scanned matrix
    localparam int DEF_ROW_W      = 5;  // LEDs per row pattern
    localparam int DEF_NUM_ROWS   = 7;  // stored row patterns
    localparam int DEF_DWELL_BITS = 3;  // log2 of clocks per slot
    localparam int DEF_SEL_BITS   = 3;  // log2 of slots per frame

    // Whether the scan position holds or moves to the next slot this cycle
    typedef enum logic {
        SCAN_HOLD = 1'b0,
        SCAN_STEP = 1'b1
    } scan_step_e;

    function automatic int slot_count(input int sel_bits);
        return 1 << sel_bits;
    endfunction

endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
    parameter int DWELL_BITS = 3,
    parameter int SEL_BITS   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [SEL_BITS-1:0]     sel_o,
    output led_scan_pkg::scan_step_e step_o
);
    import led_scan_pkg::*;

    // The low slice of the scan position: a power-of-two dwell prescaler
    logic [DWELL_BITS-1:0] dwell_q;

    // The slot advances when the prescaler is about to wrap
    assign step_o = (&dwell_q) ? SCAN_STEP : SCAN_HOLD;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_q <= '0;
            sel_o   <= '0;
        end else begin
            dwell_q <= dwell_q + 1'b1;
            if (step_o == SCAN_STEP) begin
                sel_o <= sel_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/led_line_strobe.sv
module led_line_strobe #(
    parameter int NUM_SLOTS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  led_scan_pkg::scan_step_e step_i,
    output logic [NUM_SLOTS-1:0]     strobe_o
);
    import led_scan_pkg::*;

    localparam logic [NUM_SLOTS-1:0] HOME = NUM_SLOTS'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_o <= HOME;
        end else if (step_i == SCAN_STEP) begin
            strobe_o <= {strobe_o[NUM_SLOTS-2:0], strobe_o[NUM_SLOTS-1]};
        end
    end

endmodule

// File: rtl/led_row_mux.sv
module led_row_mux #(
    parameter int ROW_W    = 5,
    parameter int NUM_ROWS = 7,
    parameter int SEL_BITS = 3
) (
    input  logic [NUM_ROWS*ROW_W-1:0] rows_i,
    input  logic [SEL_BITS-1:0]       sel_i,
    output logic [ROW_W-1:0]          data_o
);
    // Unpack the flat frame image into one entry per row
    logic [ROW_W-1:0] row_arr [NUM_ROWS];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        assign row_arr[g] = rows_i[g*ROW_W +: ROW_W];
    end

    // Codes with no stored row fall through to the all-zero default
    always_comb begin
        data_o = '0;
        for (int k = 0; k < NUM_ROWS; k++) begin
            if (sel_i == SEL_BITS'(k)) begin
                data_o = row_arr[k];
            end
        end
    end

endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
    import led_scan_pkg::*;
#(
    parameter int ROW_W      = DEF_ROW_W,
    parameter int NUM_ROWS   = DEF_NUM_ROWS,
    parameter int DWELL_BITS = DEF_DWELL_BITS,
    parameter int SEL_BITS   = DEF_SEL_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_ROWS*ROW_W-1:0]     rows_i,
    output logic [ROW_W-1:0]              data_o,
    output logic [(1<<SEL_BITS)-1:0]      strobe_o
);
    localparam int NUM_SLOTS = slot_count(SEL_BITS);

    logic [SEL_BITS-1:0] sel;
    scan_step_e          step;

    led_scan_timer #(
        .DWELL_BITS (DWELL_BITS),
        .SEL_BITS   (SEL_BITS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .sel_o  (sel),
        .step_o (step)
    );

    led_line_strobe #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .strobe_o (strobe_o)
    );

    led_row_mux #(
        .ROW_W    (ROW_W),
        .NUM_ROWS (NUM_ROWS),
        .SEL_BITS (SEL_BITS)
    ) u_mux (
        .rows_i (rows_i),
        .sel_i  (sel),
        .data_o (data_o)
    );

endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
    parameter int ROW_W      = 5,
    parameter int NUM_ROWS   = 7,
    parameter int DWELL_BITS = 3,
    parameter int SEL_BITS   = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_ROWS*ROW_W-1:0] rows_i,
    input logic [ROW_W-1:0]          data_o,
    input logic [(1<<SEL_BITS)-1:0]  strobe_o
);
    localparam int SLOTS = 1 << SEL_BITS;
    localparam int DWELL = 1 << DWELL_BITS;

    logic [SLOTS-1:0]    prev_strobe;
    logic [DWELL_BITS:0] hold;
    logic                armed;
    logic                changed;
    int                  lit;
    logic [ROW_W-1:0]    want_row;

    assign changed = (strobe_o != prev_strobe);

    // Index of the lit line, recovered from the strobe alone
    always_comb begin
        lit = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (strobe_o[i]) lit = i;
        end
    end

    always_comb begin
        want_row = '0;
        for (int k = 0; k < NUM_ROWS; k++) begin
            if (lit == k) want_row = rows_i[k*ROW_W +: ROW_W];
        end
    end

    // Observed dwell length; the window just after reset is not armed
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_strobe <= SLOTS'(1);
            hold        <= '0;
            armed       <= 1'b0;
        end else begin
            prev_strobe <= strobe_o;
            armed       <= armed | changed;
            hold        <= changed ? '0 : hold + 1'b1;
        end
    end

    AST_RESET_HOME: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (strobe_o == SLOTS'(1))); // R1

    AST_DWELL_LEN: assert property (@(posedge clk) disable iff (rst)
        (armed && changed) |-> (hold == (DWELL_BITS+1)'(DWELL-1))); // R2

    AST_ROW_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (lit < NUM_ROWS) |-> (data_o == want_row)); // R3

    AST_BLANK_SLOT: assert property (@(posedge clk) disable iff (rst)
        (lit >= NUM_ROWS) |-> (data_o == '0)); // R4

    AST_ONE_LINE_LIT: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe_o) == 1); // R5

    AST_STEP_ROTATES: assert property (@(posedge clk) disable iff (rst)
        changed |-> (strobe_o == {prev_strobe[SLOTS-2:0], prev_strobe[SLOTS-1]})); // R6

endmodule

bind led_scan_driver led_scan_checker #(
    .ROW_W      (ROW_W),
    .NUM_ROWS   (NUM_ROWS),
    .DWELL_BITS (DWELL_BITS),
    .SEL_BITS   (SEL_BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rows_i   (rows_i),
    .data_o   (data_o),
    .strobe_o (strobe_o)
);

// File: tb/led_scan_driver_tb.sv
module led_scan_driver_tb;
    localparam int ROW_W      = 5;
    localparam int NUM_ROWS   = 7;
    localparam int DWELL_BITS = 3;
    localparam int SEL_BITS   = 3;
    localparam int SLOTS      = 1 << SEL_BITS;
    localparam int DWELL      = 1 << DWELL_BITS;
    localparam int FRAME      = SLOTS * DWELL;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [NUM_ROWS*ROW_W-1:0] rows = '0;
    logic [ROW_W-1:0]          data_o;
    logic [SLOTS-1:0]          strobe_o;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;
    int cyc    = 0;

    // Dwell tracking state
    logic [SLOTS-1:0] prev_s = '0;
    int               run_len = 0;
    bit               armed = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    led_scan_driver #(
        .ROW_W      (ROW_W),
        .NUM_ROWS   (NUM_ROWS),
        .DWELL_BITS (DWELL_BITS),
        .SEL_BITS   (SEL_BITS)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .rows_i   (rows),
        .data_o   (data_o),
        .strobe_o (strobe_o)
    );

    // Reference scan position
    always @(posedge clk) begin
        if (rst) mcnt = 0;
        else     mcnt = (mcnt + 1) % FRAME;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [ROW_W-1:0] exp_row(input logic [NUM_ROWS*ROW_W-1:0] r, input int code);
        logic [ROW_W-1:0] v = '0;
        for (int k = 0; k < NUM_ROWS; k++) begin
            if (k == code) v = r[k*ROW_W +: ROW_W];
        end
        return v;
    endfunction

    function automatic logic [SLOTS-1:0] exp_strobe(input int code);
        return SLOTS'(1) << code;
    endfunction

    function automatic logic [NUM_ROWS*ROW_W-1:0] rand_rows();
        logic [NUM_ROWS*ROW_W-1:0] v;
        for (int k = 0; k < NUM_ROWS; k++) v[k*ROW_W +: ROW_W] = ROW_W'($urandom);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge, before any input is changed
    task automatic sample_check(input string rst_req);
        int code;
        if (rst) begin
            check(strobe_o == SLOTS'(1), rst_req, "strobe after reset", 32'(strobe_o), 1);
            check(data_o == exp_row(rows, 0), rst_req, "data after reset",
                  32'(data_o), 32'(exp_row(rows, 0)));
            prev_s  = strobe_o;
            run_len = 0;
            armed   = 1'b0;
            return;
        end
        code = mcnt / DWELL;
        if (code < NUM_ROWS)
            check(data_o == exp_row(rows, code), "R3", "row pattern", 32'(data_o), 32'(exp_row(rows, code)));
        else
            check(data_o == '0, "R4", "blank slot", 32'(data_o), 0);
        check($countones(strobe_o) == 1, "R5", "strobe bits lit", $countones(strobe_o), 1);
        check(strobe_o == exp_strobe(code), "R6", "strobe position", 32'(strobe_o), 32'(exp_strobe(code)));
        if (mcnt == 0)
            check(strobe_o == SLOTS'(1), "R7", "frame wrap", 32'(strobe_o), 1);
        if (strobe_o != prev_s) begin
            if (armed) check(run_len == DWELL, "R2", "dwell length", run_len, DWELL);
            armed   = 1'b1;
            run_len = 1;
        end else begin
            run_len++;
        end
        prev_s = strobe_o;
    endtask

    task automatic step_to(input int code, input int phase);
        do begin
            @(negedge clk);
            sample_check("R9");
        end while (!(mcnt / DWELL == code && mcnt % DWELL == phase));
    endtask

    initial begin
        logic [ROW_W-1:0] held;
        int seed_dummy;
        seed_dummy = $urandom(2024);
        rows = rand_rows();
        rst  = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        sample_check("R1");
        rst = 1'b0;

        // Three frames with occasional frame-image changes (R2..R7)
        repeat (3 * FRAME) begin
            @(negedge clk);
            sample_check("R9");
            if ($urandom % 16 == 0) rows = rand_rows();
        end

        // R8: live row inputs, unselected row has no effect
        step_to(2, 3);
        held = data_o;
        rows[5*ROW_W +: ROW_W] = ~rows[5*ROW_W +: ROW_W];
        #1 check(data_o == held, "R8", "unselected row edit", 32'(data_o), 32'(held));
        rows[2*ROW_W +: ROW_W] = ~rows[2*ROW_W +: ROW_W];
        #1 check(data_o == exp_row(rows, 2), "R8", "selected row edit", 32'(data_o), 32'(exp_row(rows, 2)));

        // R4: all-ones image, spare slot must stay dark
        rows = '1;
        step_to(7, 4);
        check(data_o == '0, "R4", "blank slot with full image", 32'(data_o), 0);

        // R9: reset in mid-frame
        rows = rand_rows();
        step_to(4, 5);
        rst = 1'b1;
        @(negedge clk);
        sample_check("R9");
        rst = 1'b0;
        // R9: full first dwell after the restart
        repeat (DWELL - 1) begin
            @(negedge clk);
            sample_check("R9");
            check(strobe_o == SLOTS'(1), "R9", "first dwell after restart", 32'(strobe_o), 1);
        end
        @(negedge clk);
        sample_check("R9");
        check(strobe_o == SLOTS'(2), "R9", "advance after first dwell", 32'(strobe_o), 2);

        // Random phase: image churn and rare reset pulses
        repeat (3000) begin
            @(negedge clk);
            sample_check("R9");
            rst = 1'b0;
            if ($urandom % 8 == 0) rows = rand_rows();
            if ($urandom % 400 == 0) rst = 1'b1;
        end
        @(negedge clk);
        sample_check("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule